// File: doc/BRIEF.md
# Low MMIO Port Address Decoder

This block decides where a 32-bit physical memory request goes when it lands in the low memory-mapped I/O window. That window starts at a programmable top-of-low-memory boundary and ends just below the fixed ceiling FE00_0000h. There are six downstream ports, numbered 2 to 7. Each port has two address windows, set by base and limit values: one for ordinary memory and one for prefetchable memory. A request that lands in the low window but in none of the port windows goes to a legacy bridge port. That port has no window registers of its own.

Base, limit and the top-of-low-memory value are all given in 1 MB units and are compared against address bits [31:20]. A prefetchable window counts only while its upper-32-bit base and limit extensions are both zero. If either one is nonzero, that window belongs to high MMIO space and the decoder ignores it. The decode is registered. The port select, the in-window flag and the overlap error appear one clock after the request is sampled.

Top module: `lmmio_port_decoder`

## Requirements
- R1: A valid request whose page `req_addr[31:20]` satisfies `tolm <= page < 12'hFE0` sets `in_window` to 1 one clock later.
- R2: A valid request whose page is below `tolm`, or is at or above 12'hFE0, gives `in_window` = 0, `port_sel` = 0 and `overlap_err` = 0 one clock later.
- R3: A page inside the low window and inside an enabled window of port p (base <= page <= limit) sets `port_sel[p-1]`, and only that bit. In `port_sel`, bit 0 is the legacy bridge and bits 1 to 6 are ports 2 to 7. Port k's fields sit at slice `[(k-2)*12 +: 12]`, or `[(k-2)*32 +: 32]` for the upper-32-bit extensions.
- R4: A page inside the low window that matches no enabled window sets exactly `port_sel[0]`, the legacy bridge.
- R5: A window whose limit is below its base is disabled and matches no page.
- R6: A prefetchable window whose upper base extension or upper limit extension is nonzero matches no page.
- R7: When two or more enabled windows match one in-window page, `overlap_err` is 1 and only the lowest-numbered matching port is selected. If a port's own two windows both match, that counts as an overlap too.
- R8: All outputs are registered: they follow the request sampled at the previous rising edge. A cycle with `req_valid` low gives all-zero outputs one clock later.
- R9: While synchronous reset `rst` is high, all outputs are zero at the next edge, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request physical address |
| tolm | input | 12 | Top of low memory, in 1 MB units |
| mem_base | input | 72 | Memory window base for each port, 12 bits per port |
| mem_limit | input | 72 | Memory window limit for each port, 12 bits per port |
| pf_base | input | 72 | Prefetchable window base for each port, 12 bits per port |
| pf_limit | input | 72 | Prefetchable window limit for each port, 12 bits per port |
| pf_base_hi | input | 192 | Upper 32-bit base extension of each prefetchable window |
| pf_limit_hi | input | 192 | Upper 32-bit limit extension of each prefetchable window |
| port_sel | output | 7 | One-hot destination; bit 0 is the legacy bridge |
| in_window | output | 1 | Request was inside the low MMIO window |
| overlap_err | output | 1 | More than one enabled window matched |

## Verification
The assertions assume that the configuration inputs hold steady around each request. They also assume that `tolm` does not exceed the ceiling, so the in-range test is a plain comparison of the sampled inputs. The bench changes the window settings only between sweeps. In each sweep it steps through every 1 MB page once and fills the low address bits with a changing pattern. Its configurations include windows set legally, a disabled window, a window lifted to high space, deliberate overlaps and an empty low window. Overlaps and empty windows are configuration errors, and the decoder must still handle them deterministically.

// File: rtl/lmmio_port_decoder.sv
module lmmio_port_decoder #(
  parameter int NPORTS = 6,
  parameter int AW     = 32,
  parameter int GW     = 12,
  parameter int HW     = 32,
  parameter logic [GW-1:0] CEIL = 12'hFE0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  input  logic [GW-1:0]        tolm,
  input  logic [NPORTS*GW-1:0] mem_base,
  input  logic [NPORTS*GW-1:0] mem_limit,
  input  logic [NPORTS*GW-1:0] pf_base,
  input  logic [NPORTS*GW-1:0] pf_limit,
  input  logic [NPORTS*HW-1:0] pf_base_hi,
  input  logic [NPORTS*HW-1:0] pf_limit_hi,
  output logic [NPORTS:0]      port_sel,
  output logic                 in_window,
  output logic                 overlap_err
);
  localparam int LSB = AW - GW;

  logic [GW-1:0]     page;
  logic              in_rng;
  logic [NPORTS-1:0] mem_hit, pf_hit, port_hit;
  logic [NPORTS:0]   sel_d;
  logic              err_d;

  assign page   = req_addr[AW-1:LSB];
  assign in_rng = (page >= tolm) && (page < CEIL);

  for (genvar i = 0; i < NPORTS; i++) begin : g_win
    logic [GW-1:0] mb, ml, pb, pl;
    logic          pf_low;
    assign mb = mem_base[i*GW +: GW];
    assign ml = mem_limit[i*GW +: GW];
    assign pb = pf_base[i*GW +: GW];
    assign pl = pf_limit[i*GW +: GW];
    assign pf_low = (pf_base_hi[i*HW +: HW] == '0) && (pf_limit_hi[i*HW +: HW] == '0);
    assign mem_hit[i] = in_rng && (mb <= ml) && (page >= mb) && (page <= ml);
    assign pf_hit[i]  = in_rng && pf_low && (pb <= pl) && (page >= pb) && (page <= pl);
  end

  assign port_hit = mem_hit | pf_hit;
  assign err_d    = $countones({mem_hit, pf_hit}) > 1;

  always_comb begin
    logic found;
    found = 1'b0;
    sel_d = '0;
    if (in_rng) begin
      for (int i = 0; i < NPORTS; i++) begin
        if (port_hit[i] && !found) begin
          sel_d[i+1] = 1'b1;
          found      = 1'b1;
        end
      end
      if (!found) sel_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      port_sel    <= '0;
      in_window   <= 1'b0;
      overlap_err <= 1'b0;
    end else begin
      port_sel    <= sel_d;
      in_window   <= in_rng;
      overlap_err <= err_d;
    end
  end
endmodule

module lmmio_port_decoder_chk #(
  parameter int NPORTS = 6,
  parameter int AW     = 32,
  parameter int GW     = 12,
  parameter logic [GW-1:0] CEIL = 12'hFE0
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [AW-1:0]   req_addr,
  input logic [GW-1:0]   tolm,
  input logic [NPORTS:0] port_sel,
  input logic            in_window,
  input logic            overlap_err
);
  localparam int LSB = AW - GW;

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_sel));

  p_sel_iff_window_r4: assert property (@(posedge clk) disable iff (rst)
    in_window == (port_sel != '0));

  p_out_of_range_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ((req_addr[AW-1:LSB] < tolm) || (req_addr[AW-1:LSB] >= CEIL)))
    |=> (!in_window && port_sel == '0 && !overlap_err));

  p_idle_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (port_sel == '0 && !in_window && !overlap_err));

  p_err_in_port_r7: assert property (@(posedge clk) disable iff (rst)
    overlap_err |-> (in_window && !port_sel[0]));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (port_sel == '0 && !in_window && !overlap_err));
endmodule

bind lmmio_port_decoder lmmio_port_decoder_chk #(
  .NPORTS(NPORTS), .AW(AW), .GW(GW), .CEIL(CEIL)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .tolm(tolm),
  .port_sel(port_sel), .in_window(in_window), .overlap_err(overlap_err)
);

// File: tb/lmmio_port_decoder_tb.sv
module lmmio_port_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [11:0] tolm = '0;
  logic [NP*12-1:0] mem_base = '0, mem_limit = '0, pf_base = '0, pf_limit = '0;
  logic [NP*32-1:0] pf_base_hi = '0, pf_limit_hi = '0;
  logic [NP:0] port_sel;
  logic in_window, overlap_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lmmio_port_decoder dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .tolm(tolm),
    .mem_base(mem_base), .mem_limit(mem_limit), .pf_base(pf_base), .pf_limit(pf_limit),
    .pf_base_hi(pf_base_hi), .pf_limit_hi(pf_limit_hi),
    .port_sel(port_sel), .in_window(in_window), .overlap_err(overlap_err)
  );

  task automatic set_port(input int p, input logic [11:0] mb, ml, pb, pl,
                          input logic [31:0] hb, hl);
    mem_base[(p-2)*12 +: 12]    = mb;
    mem_limit[(p-2)*12 +: 12]   = ml;
    pf_base[(p-2)*12 +: 12]     = pb;
    pf_limit[(p-2)*12 +: 12]    = pl;
    pf_base_hi[(p-2)*32 +: 32]  = hb;
    pf_limit_hi[(p-2)*32 +: 32] = hl;
  endtask

  task automatic clear_ports();
    for (int p = 2; p <= 7; p++) set_port(p, 12'h001, 12'h000, 12'h001, 12'h000, 0, 0);
  endtask

  task automatic check(input string req, input logic [NP:0] es, input logic ei, input logic ee);
    n_tests++;
    if (port_sel !== es || in_window !== ei || overlap_err !== ee) begin
      n_fail++;
      $display("FAIL %s addr=%h sel=%b/%b win=%b/%b err=%b/%b (actual/expected)",
               req, req_addr, port_sel, es, in_window, ei, overlap_err, ee);
    end
  endtask

  task automatic sweep(input int seed);
    for (int pg = 0; pg < 4096; pg++) begin
      logic [NP:0] es;
      logic ei, ee;
      int nwin, first;
      string req;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = {pg[11:0], 20'(pg * 37 + seed * 4099)};
      ei = (pg >= int'(tolm)) && (pg < 'hFE0);
      nwin = 0; first = 0; es = '0;
      req = ei ? "R1/R4" : "R2";
      if (ei) begin
        for (int p = 7; p >= 2; p--) begin
          int mb, ml, pb, pl;
          bit mh, ph, pfdis;
          mb = int'(mem_base[(p-2)*12 +: 12]); ml = int'(mem_limit[(p-2)*12 +: 12]);
          pb = int'(pf_base[(p-2)*12 +: 12]);  pl = int'(pf_limit[(p-2)*12 +: 12]);
          pfdis = (pf_base_hi[(p-2)*32 +: 32] != 0) || (pf_limit_hi[(p-2)*32 +: 32] != 0);
          mh = (pg >= mb) && (pg <= ml);
          ph = !pfdis && (pg >= pb) && (pg <= pl);
          if (mb > ml && pg >= ml && pg <= mb) req = "R5";
          if (pfdis && pg >= pb && pg <= pl) req = "R6";
          nwin += int'(mh) + int'(ph);
          if (mh || ph) first = p;
        end
        if (first != 0) begin es[first-1] = 1'b1; req = "R3"; end
        else es[0] = 1'b1;
      end
      ee = nwin > 1;
      if (ee) req = "R7";
      @(negedge clk);
      check(req, es, ei, ee);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h9000_0000;
    tolm      = 12'h800;
    @(negedge clk);
    check("R9", '0, 1'b0, 1'b0);
    rst = 1'b0;

    clear_ports();
    set_port(2, 12'h800, 12'h80F, 12'h810, 12'h81F, 0, 0);
    set_port(3, 12'h900, 12'h90F, 12'h001, 12'h000, 0, 0);
    set_port(4, 12'hA00, 12'h9FF, 12'h001, 12'h000, 0, 0);
    set_port(5, 12'h001, 12'h000, 12'hB00, 12'hB0F, 32'h1, 0);
    set_port(6, 12'hC00, 12'hC00, 12'hC10, 12'hC1F, 0, 32'h2);
    set_port(7, 12'hFDF, 12'hFDF, 12'h001, 12'h000, 0, 0);
    sweep(1);

    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 32'h9000_0000;
    @(negedge clk);
    check("R8", '0, 1'b0, 1'b0);
    req_valid = 1'b1;
    @(negedge clk);
    check("R8", 7'b0000100, 1'b1, 1'b0);

    clear_ports();
    tolm = 12'hC00;
    set_port(3, 12'hD00, 12'hD3F, 12'h001, 12'h000, 0, 0);
    set_port(5, 12'h001, 12'h000, 12'hD20, 12'hD2F, 0, 0);
    set_port(2, 12'hE00, 12'hE0F, 12'hE08, 12'hE1F, 0, 0);
    set_port(7, 12'hE10, 12'hE10, 12'h001, 12'h000, 0, 0);
    set_port(6, 12'hC00, 12'hC01, 12'hFDE, 12'hFDF, 0, 0);
    sweep(2);

    clear_ports();
    tolm = 12'hFE0;
    set_port(4, 12'hFE0, 12'hFFF, 12'h001, 12'h000, 0, 0);
    sweep(3);

    @(negedge clk);
    tolm = 12'h000;
    req_valid = 1'b1;
    req_addr  = 32'h1234_5678;
    @(negedge clk);
    check("R4", 7'b0000001, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R9", '0, 1'b0, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: expected=done actual=hung");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule